// File: doc/BRIEF.md
# Breakpoint and Watchpoint Match Unit

This block spots software debug events as they happen on the instruction fetch path and the data access path. Each fetched instruction is compared against a bank of breakpoint comparators and a vector-catch table, and it is flagged if it is itself a breakpoint instruction. A comparator can match or mismatch on the fetch address, or it can watch the current context ID. An address comparator, and also a watchpoint, can be qualified by a linked context-ID comparator. Data accesses are compared against a separate bank of watchpoint comparators.

All fetch-side conditions are judged in the fetch cycle. The outcome is condensed to one event-type tag per instruction, and that tag is kept in an in-order queue until the instruction commits or the pipeline is flushed. An event is reported only when the tagged instruction commits. A watchpoint hit is reported one cycle after the data access. A downstream debug controller uses the type code to decide between halting, taking an exception or ignoring the event.

Top module: `bpwp_match_unit`

## Requirements
- R1: After reset the tag queue is empty and both event outputs are idle: a commit strobe with no prior fetch raises no event, and the event types read 0.
- R2: An enabled address comparator (context mode off, mismatch bit clear) whose value equals the fetch address tags the instruction with type 1.
- R3: An enabled address comparator with its mismatch bit set tags type 3 when the fetch address differs from its value, and tags nothing when the two are equal.
- R4: An enabled comparator in context mode, with its link bit clear, tags type 2 when the context ID equals its value. With its link bit set it serves only as a link source and tags nothing by itself.
- R5: When an address comparator or watchpoint has its link bit set, it hits only if the comparator at its link index is enabled, in context mode and equal to the current context ID. A link index of 6 or more never qualifies.
- R6: Comparator settings and the context ID are taken in the fetch cycle: changes made between fetch and commit do not alter the reported event.
- R7: Each commit strobe retires the oldest pending instruction, in fetch order. The cycle after the strobe, the instruction event output shows valid with the tag when the tag is nonzero, and shows invalid with type 0 otherwise.
- R8: A flush empties the queue in one cycle. A fetch or commit presented in the same cycle as the flush is discarded, and no event follows it.
- R9: A fetch from vector address VEC_BASE+4*i (i from 0 to 7) tags type 4 when catch bit i of the mask for the current world is set. The secure mask applies when the world input is 1 and the non-secure mask applies when it is 0.
- R10: A fetch marked as a breakpoint instruction tags type 5 with no comparator involved.
- R11: When several causes apply to one fetch, the tag follows the order type 5, then 4, 2, 1 and 3.
- R12: A data access that matches an enabled watchpoint (with its link qualified) sets that watchpoint's bit in the mask the next cycle, together with valid and type 6. An access that matches nothing gives an empty mask and type 0.
- R13: The queue holds 4 instructions. A fetch that arrives while the queue is full and no commit is presented is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction is fetched this cycle |
| fetch_addr | input | 32 | Fetch address |
| fetch_is_bkpt | input | 1 | The fetched instruction is a breakpoint instruction |
| secure_world | input | 1 | 1 = secure world, 0 = non-secure world |
| ctx_id | input | 32 | Current context ID |
| commit | input | 1 | Oldest pending instruction commits |
| flush | input | 1 | Discard all pending instructions |
| data_valid | input | 1 | A data access occurs this cycle |
| data_addr | input | 32 | Data access address |
| bp_value | input | 6x32 | Breakpoint comparator values |
| bp_enable | input | 6 | Breakpoint comparator enables |
| bp_mismatch | input | 6 | Breakpoint fires on address mismatch |
| bp_ctx_mode | input | 6 | Comparator compares the context ID |
| bp_link_en | input | 6 | Link to a context comparator (for a context comparator: link source only) |
| bp_link_idx | input | 6x3 | Linked comparator index |
| wp_value | input | 2x32 | Watchpoint values |
| wp_enable | input | 2 | Watchpoint enables |
| wp_link_en | input | 2 | Watchpoint link enable |
| wp_link_idx | input | 2x3 | Watchpoint linked comparator index |
| vc_mask_sec | input | 8 | Vector catch bits, secure world |
| vc_mask_nsec | input | 8 | Vector catch bits, non-secure world |
| ins_evt_valid | output | 1 | Instruction-side event pulse |
| ins_evt_type | output | 3 | Instruction event type code |
| wp_evt_valid | output | 1 | Watchpoint event pulse |
| wp_evt_type | output | 3 | 6 on a watchpoint event, else 0 |
| wp_evt_mask | output | 2 | Watchpoints that hit |

## Verification
The hardest condition to reach is a hit whose qualifying state is gone by commit time. This happens when the comparator enable or the context ID changes while the tag waits in the queue, or when a flush lands in the same cycle as a new fetch. The directed tasks hold instructions in the queue across reprogramming. They fill the queue to capacity before they commit, and they raise flush together with fetch. After each of these, they commit again and check that no stale or dropped tag comes out.

// File: rtl/bpwp_pkg.sv
package bpwp_pkg;
    typedef enum logic [2:0] {
        EVT_NONE   = 3'd0,
        EVT_ADDR   = 3'd1,
        EVT_CTX    = 3'd2,
        EVT_MISM   = 3'd3,
        EVT_VCATCH = 3'd4,
        EVT_SWBK   = 3'd5,
        EVT_WATCH  = 3'd6
    } evt_e;
endpackage

// File: rtl/bpwp_bp_bank.sv
module bpwp_bp_bank #(
    parameter int NUM_BP = 6,
    parameter int AW     = 32,
    localparam int LW    = $clog2(NUM_BP)
) (
    input  logic [AW-1:0]              fetch_addr,
    input  logic [AW-1:0]              ctx_id,
    input  logic [NUM_BP-1:0][AW-1:0]  bp_value,
    input  logic [NUM_BP-1:0]          bp_enable,
    input  logic [NUM_BP-1:0]          bp_mismatch,
    input  logic [NUM_BP-1:0]          bp_ctx_mode,
    input  logic [NUM_BP-1:0]          bp_link_en,
    input  logic [NUM_BP-1:0][LW-1:0]  bp_link_idx,
    output logic [NUM_BP-1:0]          ctx_match,
    output logic                       any_addr,
    output logic                       any_ctx,
    output logic                       any_mism
);
    logic [NUM_BP-1:0] link_ok, hit_addr, hit_ctx, hit_mism;

    always_comb begin
        for (int i = 0; i < NUM_BP; i++)
            ctx_match[i] = bp_enable[i] & bp_ctx_mode[i] & (bp_value[i] == ctx_id);
    end

    always_comb begin
        for (int i = 0; i < NUM_BP; i++) begin
            link_ok[i] = !bp_link_en[i];
            for (int j = 0; j < NUM_BP; j++)
                if (bp_link_en[i] && bp_link_idx[i] == LW'(j))
                    link_ok[i] = ctx_match[j];
        end
    end

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        logic addr_eq;
        logic addr_slot;
        assign addr_eq     = (fetch_addr == bp_value[g]);
        assign addr_slot   = bp_enable[g] & !bp_ctx_mode[g] & link_ok[g];
        assign hit_addr[g] = addr_slot & !bp_mismatch[g] & addr_eq;
        assign hit_mism[g] = addr_slot & bp_mismatch[g] & !addr_eq;
        assign hit_ctx[g]  = ctx_match[g] & !bp_link_en[g];
    end

    assign any_addr = |hit_addr;
    assign any_ctx  = |hit_ctx;
    assign any_mism = |hit_mism;
endmodule

// File: rtl/bpwp_wp_bank.sv
module bpwp_wp_bank #(
    parameter int NUM_WP = 2,
    parameter int NUM_BP = 6,
    parameter int AW     = 32,
    localparam int LW    = $clog2(NUM_BP)
) (
    input  logic                       data_valid,
    input  logic [AW-1:0]              data_addr,
    input  logic [NUM_BP-1:0]          ctx_match,
    input  logic [NUM_WP-1:0][AW-1:0]  wp_value,
    input  logic [NUM_WP-1:0]          wp_enable,
    input  logic [NUM_WP-1:0]          wp_link_en,
    input  logic [NUM_WP-1:0][LW-1:0]  wp_link_idx,
    output logic [NUM_WP-1:0]          wp_hit
);
    always_comb begin
        for (int i = 0; i < NUM_WP; i++) begin
            logic lok;
            lok = !wp_link_en[i];
            for (int j = 0; j < NUM_BP; j++)
                if (wp_link_en[i] && wp_link_idx[i] == LW'(j))
                    lok = ctx_match[j];
            wp_hit[i] = data_valid & wp_enable[i] & (data_addr == wp_value[i]) & lok;
        end
    end
endmodule

// File: rtl/bpwp_vcatch.sv
module bpwp_vcatch #(
    parameter int          AW       = 32,
    parameter int          NUM_VEC  = 8,
    parameter logic [31:0] VEC_BASE = 32'h0
) (
    input  logic [AW-1:0]      fetch_addr,
    input  logic               secure_world,
    input  logic [NUM_VEC-1:0] vc_mask_sec,
    input  logic [NUM_VEC-1:0] vc_mask_nsec,
    output logic               vc_hit
);
    logic [NUM_VEC-1:0] slot_hit;

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        localparam logic [AW-1:0] VADDR = AW'(VEC_BASE) + AW'(4 * g);
        assign slot_hit[g] = (fetch_addr == VADDR) &
                             (secure_world ? vc_mask_sec[g] : vc_mask_nsec[g]);
    end

    assign vc_hit = |slot_hit;
endmodule

// File: rtl/bpwp_tag_queue.sv
module bpwp_tag_queue
    import bpwp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_valid,
    input  evt_e fetch_tag,
    input  logic commit,
    input  logic flush,
    output evt_e head_tag,
    output logic pop_fire
);
    typedef struct packed {
        evt_e [DEPTH-1:0] tag;
        logic [CW-1:0]    cnt;
    } q_t;

    q_t   st_d, st_q;
    logic pop, push;

    always_comb begin
        st_d = st_q;
        pop  = commit && (st_q.cnt != '0);
        push = fetch_valid && ((st_q.cnt != CW'(DEPTH)) || pop);
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++)
                st_d.tag[i] = st_q.tag[i+1];
            st_d.tag[DEPTH-1] = EVT_NONE;
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (push) begin
            for (int i = 0; i < DEPTH; i++)
                if (CW'(i) == st_d.cnt)
                    st_d.tag[i] = fetch_tag;
            st_d.cnt = st_d.cnt + 1'b1;
        end
        if (flush) begin
            for (int i = 0; i < DEPTH; i++)
                st_d.tag[i] = EVT_NONE;
            st_d.cnt = '0;
        end
        head_tag = st_q.tag[0];
        pop_fire = pop && !flush;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                st_q.tag[i] <= EVT_NONE;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bpwp_match_unit.sv
module bpwp_match_unit
    import bpwp_pkg::*;
#(
    parameter int          NUM_BP   = 6,
    parameter int          NUM_WP   = 2,
    parameter int          AW       = 32,
    parameter int          NUM_VEC  = 8,
    parameter int          DEPTH    = 4,
    parameter logic [31:0] VEC_BASE = 32'h0,
    localparam int         LW       = $clog2(NUM_BP)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fetch_valid,
    input  logic [AW-1:0]              fetch_addr,
    input  logic                       fetch_is_bkpt,
    input  logic                       secure_world,
    input  logic [AW-1:0]              ctx_id,
    input  logic                       commit,
    input  logic                       flush,
    input  logic                       data_valid,
    input  logic [AW-1:0]              data_addr,
    input  logic [NUM_BP-1:0][AW-1:0]  bp_value,
    input  logic [NUM_BP-1:0]          bp_enable,
    input  logic [NUM_BP-1:0]          bp_mismatch,
    input  logic [NUM_BP-1:0]          bp_ctx_mode,
    input  logic [NUM_BP-1:0]          bp_link_en,
    input  logic [NUM_BP-1:0][LW-1:0]  bp_link_idx,
    input  logic [NUM_WP-1:0][AW-1:0]  wp_value,
    input  logic [NUM_WP-1:0]          wp_enable,
    input  logic [NUM_WP-1:0]          wp_link_en,
    input  logic [NUM_WP-1:0][LW-1:0]  wp_link_idx,
    input  logic [NUM_VEC-1:0]         vc_mask_sec,
    input  logic [NUM_VEC-1:0]         vc_mask_nsec,
    output logic                       ins_evt_valid,
    output logic [2:0]                 ins_evt_type,
    output logic                       wp_evt_valid,
    output logic [2:0]                 wp_evt_type,
    output logic [NUM_WP-1:0]          wp_evt_mask
);
    typedef struct packed {
        logic              ins_valid;
        evt_e              ins_type;
        logic              wp_valid;
        evt_e              wp_type;
        logic [NUM_WP-1:0] wp_mask;
    } out_t;

    out_t              out_d, out_q;
    logic [NUM_BP-1:0] ctx_match;
    logic              any_addr, any_ctx, any_mism, vc_hit, pop_fire;
    logic [NUM_WP-1:0] wp_hit;
    evt_e              fetch_tag, head_tag;

    bpwp_bp_bank #(.NUM_BP(NUM_BP), .AW(AW)) i_bp_bank (
        .fetch_addr (fetch_addr),
        .ctx_id     (ctx_id),
        .bp_value   (bp_value),
        .bp_enable  (bp_enable),
        .bp_mismatch(bp_mismatch),
        .bp_ctx_mode(bp_ctx_mode),
        .bp_link_en (bp_link_en),
        .bp_link_idx(bp_link_idx),
        .ctx_match  (ctx_match),
        .any_addr   (any_addr),
        .any_ctx    (any_ctx),
        .any_mism   (any_mism)
    );

    bpwp_wp_bank #(.NUM_WP(NUM_WP), .NUM_BP(NUM_BP), .AW(AW)) i_wp_bank (
        .data_valid (data_valid),
        .data_addr  (data_addr),
        .ctx_match  (ctx_match),
        .wp_value   (wp_value),
        .wp_enable  (wp_enable),
        .wp_link_en (wp_link_en),
        .wp_link_idx(wp_link_idx),
        .wp_hit     (wp_hit)
    );

    bpwp_vcatch #(.AW(AW), .NUM_VEC(NUM_VEC), .VEC_BASE(VEC_BASE)) i_vcatch (
        .fetch_addr  (fetch_addr),
        .secure_world(secure_world),
        .vc_mask_sec (vc_mask_sec),
        .vc_mask_nsec(vc_mask_nsec),
        .vc_hit      (vc_hit)
    );

    bpwp_tag_queue #(.DEPTH(DEPTH)) i_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_valid(fetch_valid),
        .fetch_tag  (fetch_tag),
        .commit     (commit),
        .flush      (flush),
        .head_tag   (head_tag),
        .pop_fire   (pop_fire)
    );

    always_comb begin
        if (fetch_is_bkpt)  fetch_tag = EVT_SWBK;
        else if (vc_hit)    fetch_tag = EVT_VCATCH;
        else if (any_ctx)   fetch_tag = EVT_CTX;
        else if (any_addr)  fetch_tag = EVT_ADDR;
        else if (any_mism)  fetch_tag = EVT_MISM;
        else                fetch_tag = EVT_NONE;

        out_d.ins_valid = pop_fire && (head_tag != EVT_NONE);
        out_d.ins_type  = out_d.ins_valid ? head_tag : EVT_NONE;
        out_d.wp_mask   = wp_hit;
        out_d.wp_valid  = |wp_hit;
        out_d.wp_type   = (|wp_hit) ? EVT_WATCH : EVT_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.ins_valid <= 1'b0;
            out_q.ins_type  <= EVT_NONE;
            out_q.wp_valid  <= 1'b0;
            out_q.wp_type   <= EVT_NONE;
            out_q.wp_mask   <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ins_evt_valid = out_q.ins_valid;
    assign ins_evt_type  = out_q.ins_type;
    assign wp_evt_valid  = out_q.wp_valid;
    assign wp_evt_type   = out_q.wp_type;
    assign wp_evt_mask   = out_q.wp_mask;
endmodule

// File: rtl/bpwp_match_checker.sv
module bpwp_match_checker #(
    parameter int NUM_WP = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              flush,
    input logic              data_valid,
    input logic              ins_evt_valid,
    input logic [2:0]        ins_evt_type,
    input logic              wp_evt_valid,
    input logic [2:0]        wp_evt_type,
    input logic [NUM_WP-1:0] wp_evt_mask
);
    AST_EVT_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ins_evt_valid |-> $past(commit)); // R7

    AST_NO_EVT_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> !ins_evt_valid); // R8

    AST_IDLE_TYPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_evt_valid |-> (ins_evt_type == 3'd0)); // R7

    AST_EVT_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ins_evt_valid |-> (ins_evt_type != 3'd0 && ins_evt_type <= 3'd5)); // R11

    AST_WP_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        wp_evt_valid |-> $past(data_valid)); // R12

    AST_WP_MASK_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        wp_evt_valid == (wp_evt_mask != '0)); // R12

    AST_WP_TYPE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        wp_evt_type == (wp_evt_valid ? 3'd6 : 3'd0)); // R12
endmodule

bind bpwp_match_unit bpwp_match_checker #(.NUM_WP(NUM_WP)) i_match_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit       (commit),
    .flush        (flush),
    .data_valid   (data_valid),
    .ins_evt_valid(ins_evt_valid),
    .ins_evt_type (ins_evt_type),
    .wp_evt_valid (wp_evt_valid),
    .wp_evt_type  (wp_evt_type),
    .wp_evt_mask  (wp_evt_mask)
);

// File: tb/test_bpwp_match_unit.sv
module test_bpwp_match_unit;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fetch_valid = 1'b0, fetch_is_bkpt = 1'b0, secure_world = 1'b0;
    logic [31:0]      fetch_addr = '0, ctx_id = '0, data_addr = '0;
    logic             commit = 1'b0, flush = 1'b0, data_valid = 1'b0;
    logic [5:0][31:0] bp_value;
    logic [5:0]       bp_enable, bp_mismatch, bp_ctx_mode, bp_link_en;
    logic [5:0][2:0]  bp_link_idx;
    logic [1:0][31:0] wp_value;
    logic [1:0]       wp_enable, wp_link_en;
    logic [1:0][2:0]  wp_link_idx;
    logic [7:0]       vc_mask_sec, vc_mask_nsec;
    logic             ins_evt_valid, wp_evt_valid;
    logic [2:0]       ins_evt_type, wp_evt_type;
    logic [1:0]       wp_evt_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bpwp_match_unit i_bpwp_match_unit (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_is_bkpt(fetch_is_bkpt), .secure_world(secure_world), .ctx_id(ctx_id),
        .commit(commit), .flush(flush), .data_valid(data_valid), .data_addr(data_addr),
        .bp_value(bp_value), .bp_enable(bp_enable), .bp_mismatch(bp_mismatch),
        .bp_ctx_mode(bp_ctx_mode), .bp_link_en(bp_link_en), .bp_link_idx(bp_link_idx),
        .wp_value(wp_value), .wp_enable(wp_enable), .wp_link_en(wp_link_en),
        .wp_link_idx(wp_link_idx), .vc_mask_sec(vc_mask_sec), .vc_mask_nsec(vc_mask_nsec),
        .ins_evt_valid(ins_evt_valid), .ins_evt_type(ins_evt_type),
        .wp_evt_valid(wp_evt_valid), .wp_evt_type(wp_evt_type), .wp_evt_mask(wp_evt_mask)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_cfg();
        bp_value = '0; bp_enable = '0; bp_mismatch = '0; bp_ctx_mode = '0;
        bp_link_en = '0; bp_link_idx = '0;
        wp_value = '0; wp_enable = '0; wp_link_en = '0; wp_link_idx = '0;
        vc_mask_sec = '0; vc_mask_nsec = '0; ctx_id = '0; secure_world = 1'b0;
    endtask

    task automatic fetch(input logic [31:0] a, input logic bk);
        fetch_valid = 1'b1; fetch_addr = a; fetch_is_bkpt = bk;
        @(negedge clk);
        fetch_valid = 1'b0; fetch_is_bkpt = 1'b0;
    endtask

    task automatic commit_expect(input string req, input logic [2:0] exp);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        check(req, {28'd0, ins_evt_valid, ins_evt_type}, {28'd0, exp != 3'd0, exp});
    endtask

    task automatic wp_access(input string req, input logic [31:0] a, input logic [1:0] exp);
        data_valid = 1'b1; data_addr = a;
        @(negedge clk);
        data_valid = 1'b0;
        check(req, {26'd0, wp_evt_valid, wp_evt_type, wp_evt_mask},
              {26'd0, exp != 2'd0, (exp != 2'd0) ? 3'd6 : 3'd0, exp});
    endtask

    task automatic t_reset();
        check("R1 idle after reset", {28'd0, ins_evt_valid, ins_evt_type}, 32'd0);
        check("R1 wp idle after reset", {26'd0, wp_evt_valid, wp_evt_type, wp_evt_mask}, 32'd0);
        commit_expect("R1 commit on empty queue", 3'd0);
    endtask

    task automatic t_addr();
        clear_cfg();
        bp_value[2] = 32'h1000; bp_enable[2] = 1'b1;
        fetch(32'h1000, 1'b0); commit_expect("R2 address match", 3'd1);
        fetch(32'h1004, 1'b0); commit_expect("R2 no match other address", 3'd0);
    endtask

    task automatic t_mism();
        clear_cfg();
        bp_value[1] = 32'h2000; bp_enable[1] = 1'b1; bp_mismatch[1] = 1'b1;
        fetch(32'h2004, 1'b0); commit_expect("R3 mismatch fires", 3'd3);
        fetch(32'h2000, 1'b0); commit_expect("R3 equal address silent", 3'd0);
    endtask

    task automatic t_ctx();
        clear_cfg();
        bp_value[4] = 32'h55; bp_enable[4] = 1'b1; bp_ctx_mode[4] = 1'b1;
        ctx_id = 32'h55;
        fetch(32'h3000, 1'b0); commit_expect("R4 context breakpoint", 3'd2);
        ctx_id = 32'h56;
        fetch(32'h3000, 1'b0); commit_expect("R4 context differs", 3'd0);
        ctx_id = 32'h55; bp_link_en[4] = 1'b1;
        fetch(32'h3000, 1'b0); commit_expect("R4 link-source only silent", 3'd0);
    endtask

    task automatic t_link();
        clear_cfg();
        bp_value[5] = 32'h77; bp_enable[5] = 1'b1; bp_ctx_mode[5] = 1'b1; bp_link_en[5] = 1'b1;
        bp_value[0] = 32'h4000; bp_enable[0] = 1'b1; bp_link_en[0] = 1'b1; bp_link_idx[0] = 3'd5;
        ctx_id = 32'h77;
        fetch(32'h4000, 1'b0); commit_expect("R5 linked context equal", 3'd1);
        ctx_id = 32'h78;
        fetch(32'h4000, 1'b0); commit_expect("R5 linked context differs", 3'd0);
        ctx_id = 32'h77; bp_enable[5] = 1'b0;
        fetch(32'h4000, 1'b0); commit_expect("R5 linked comparator disabled", 3'd0);
        bp_enable[5] = 1'b1; bp_link_idx[0] = 3'd7;
        fetch(32'h4000, 1'b0); commit_expect("R5 out-of-range link index", 3'd0);
        wp_value[1] = 32'h9000; wp_enable[1] = 1'b1; wp_link_en[1] = 1'b1; wp_link_idx[1] = 3'd5;
        wp_access("R5 watchpoint link ok", 32'h9000, 2'b10);
        ctx_id = 32'h1;
        wp_access("R5 watchpoint link fails", 32'h9000, 2'b00);
    endtask

    task automatic t_sample();
        clear_cfg();
        bp_value[3] = 32'h5000; bp_enable[3] = 1'b1;
        fetch(32'h5000, 1'b0);
        bp_enable[3] = 1'b0;
        @(negedge clk);
        commit_expect("R6 disable after fetch keeps hit", 3'd1);
        fetch(32'h5000, 1'b0);
        bp_enable[3] = 1'b1;
        commit_expect("R6 enable after fetch gives nothing", 3'd0);
    endtask

    task automatic t_order();
        clear_cfg();
        bp_value[0] = 32'h6000; bp_enable[0] = 1'b1;
        fetch(32'h6000, 1'b0);
        fetch(32'h6100, 1'b1);
        fetch(32'h6200, 1'b0);
        commit_expect("R7 first in order", 3'd1);
        commit_expect("R7 second in order", 3'd5);
        commit_expect("R7 third in order", 3'd0);
        @(negedge clk);
        check("R7 event is single pulse", {31'd0, ins_evt_valid}, 32'd0);
    endtask

    task automatic t_flush();
        clear_cfg();
        fetch(32'h7000, 1'b1);
        fetch(32'h7004, 1'b1);
        flush = 1'b1; fetch_valid = 1'b1; fetch_is_bkpt = 1'b1;
        @(negedge clk);
        flush = 1'b0; fetch_valid = 1'b0; fetch_is_bkpt = 1'b0;
        commit_expect("R8 queue emptied by flush", 3'd0);
        fetch(32'h7008, 1'b1);
        flush = 1'b1; commit = 1'b1;
        @(negedge clk);
        flush = 1'b0; commit = 1'b0;
        check("R8 commit with flush silent", {28'd0, ins_evt_valid, ins_evt_type}, 32'd0);
        fetch(32'h700c, 1'b1);
        commit_expect("R8 fetch after flush kept", 3'd5);
    endtask

    task automatic t_vcatch();
        clear_cfg();
        vc_mask_sec[3] = 1'b1; vc_mask_nsec[6] = 1'b1;
        secure_world = 1'b1;
        fetch(32'h0000_000c, 1'b0); commit_expect("R9 secure catch", 3'd4);
        fetch(32'h0000_0018, 1'b0); commit_expect("R9 bit clear in secure mask", 3'd0);
        secure_world = 1'b0;
        fetch(32'h0000_000c, 1'b0); commit_expect("R9 wrong world", 3'd0);
        fetch(32'h0000_0018, 1'b0); commit_expect("R9 non-secure catch", 3'd4);
    endtask

    task automatic t_swbk();
        clear_cfg();
        fetch(32'h8000, 1'b1); commit_expect("R10 software breakpoint", 3'd5);
    endtask

    task automatic t_prio();
        clear_cfg();
        bp_value[0] = 32'h0c; bp_enable[0] = 1'b1;
        bp_value[1] = 32'h99; bp_enable[1] = 1'b1; bp_mismatch[1] = 1'b1;
        vc_mask_sec[3] = 1'b1; secure_world = 1'b1;
        fetch(32'h0c, 1'b1); commit_expect("R11 swbk over vcatch", 3'd5);
        fetch(32'h0c, 1'b0); commit_expect("R11 vcatch over address", 3'd4);
        vc_mask_sec = '0;
        bp_value[2] = 32'h33; bp_enable[2] = 1'b1; bp_ctx_mode[2] = 1'b1; ctx_id = 32'h33;
        fetch(32'h0c, 1'b0); commit_expect("R11 context over address", 3'd2);
        bp_enable[2] = 1'b0;
        fetch(32'h0c, 1'b0); commit_expect("R11 address over mismatch", 3'd1);
    endtask

    task automatic t_watch();
        clear_cfg();
        wp_value[0] = 32'hA000; wp_enable[0] = 1'b1;
        wp_value[1] = 32'hA000; wp_enable[1] = 1'b1;
        wp_access("R12 both watchpoints", 32'hA000, 2'b11);
        wp_enable[1] = 1'b0;
        wp_access("R12 one watchpoint", 32'hA000, 2'b01);
        wp_access("R12 no match", 32'hA004, 2'b00);
    endtask

    task automatic t_full();
        clear_cfg();
        bp_value[0] = 32'hB004; bp_enable[0] = 1'b1;
        fetch(32'hB000, 1'b0);
        fetch(32'hB004, 1'b0);
        fetch(32'hB008, 1'b0);
        fetch(32'hB00c, 1'b0);
        fetch(32'hB010, 1'b1);
        commit_expect("R13 entry 1", 3'd0);
        commit_expect("R13 entry 2", 3'd1);
        commit_expect("R13 entry 3", 3'd0);
        commit_expect("R13 entry 4", 3'd0);
        commit_expect("R13 fifth fetch dropped", 3'd0);
    endtask

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_mism();
        t_ctx();
        t_link();
        t_sample();
        t_order();
        t_flush();
        t_vcatch();
        t_swbk();
        t_prio();
        t_watch();
        t_full();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule